// File: doc/BRIEF.md
# Infrared SIR Transmit Pulse Shaper

This block sits between a UART transmitter and an infrared LED driver. It watches the serial transmit line and a 16x oversampling baud tick. For every data bit that is logic 0, including the start bit, it emits one short high pulse on the infrared output. A logic 1 bit, and the idle line, leave the output low.

The pulse width is set in one of two ways. In proportional mode the width is three baud ticks, which is 3/16 of a bit. In fixed mode the width is three periods of a reference clock. That reference clock is made by dividing the system clock by a 5-bit divisor, so the width stays the same at every baud rate. Software picks a divisor that puts the reference near 1.83 MHz; for example, 13 with a 24 MHz clock or 22 with a 40 MHz clock. This gives a width near 1.63 µs. Divisors below 4 are raised to 4. The mode and divisor are captured only when a pulse starts, so a pulse in flight always runs with the settings it began with.

Top module: `irsir_tx_mod`

## Requirements
- R1: While `rst_n` is low, and after reset until the first logic-0 bit is framed, `ir_txd_out` is low.
- R2: A transmit line held high, whether idle or carrying logic-1 data bits or a stop bit, produces no pulse.
- R3: Bits are framed on baud ticks. When the framer is idle, the first tick that sees `uart_txd` low starts a bit. A bit lasts 16 ticks. At each bit boundary a low line starts a new bit and a high line returns the framer to idle. `ir_txd_out` rises in the clock cycle right after the tick that starts a logic-0 bit.
- R4: With `mode_prop` = 1, the pulse stays high until the third baud tick after its starting tick. With ticks every T cycles, the pulse is 3·T cycles wide.
- R5: With `mode_prop` = 0 and a divisor D from 4 to 31, the pulse is exactly 3·D clock cycles wide. It is timed from the start of the bit and does not depend on the baud rate.
- R6: A divisor of 0, 1, 2 or 3 gives the same width as a divisor of 4, which is 12 cycles.
- R7: `mode_prop` and `ref_div` are sampled only in the cycle that starts a logic-0 bit. Changing them while a pulse is running changes neither its width nor its mode. The next pulse uses the new values.
- R8: Consecutive logic-0 bits each produce their own pulse. A byte of all zeros gives nine pulses, counting the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uart_txd | input | 1 | Serial transmit line from the UART; idles high |
| baud_x16_tick | input | 1 | One-cycle strobe at 16 times the baud rate |
| mode_prop | input | 1 | 1 = proportional (3/16 bit) width, 0 = fixed width |
| ref_div | input | 5 | Reference clock divisor for fixed mode; values below 4 act as 4 |
| ir_txd_out | output | 1 | Infrared transmit pulse, high = LED on |

## Verification
The bench uses the default parameters: 16 ticks per bit, a 5-bit divisor with a floor of 4, and three units per pulse. It drives a baud tick every 5 clocks, so a bit is 80 cycles long and a proportional pulse is 15 cycles. This lets it use the full divisor range in fixed mode. That range includes every clamped value below 4 and the largest divisor, 31. At 31 the pulse is 93 cycles, longer than a bit, so it runs on past the bit boundary into the following high bit. Configuration changes are made in the middle of a pulse to show that the settings are held per pulse.

// File: rtl/irsir_pkg.sv
// Package: shared types for the infrared SIR transmit pulse shaper.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package irsir_pkg;

    // Pulse shaping mode; the encoding matches the mode_prop input bit.
    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_PROP  = 1'b1
    } irsir_mode_e;

endpackage

// File: rtl/irsir_bit_framer.sv
// Module: irsir_bit_framer
// Recovers bit boundaries of the UART stream from the 16x baud tick.
// When idle, the first tick that sees the line low opens a bit. Each bit
// spans OVERSAMPLE ticks. At every boundary a low line opens the next bit
// and a high line returns the framer to idle.
// Assumes: the UART changes its line between ticks, on the same tick grid.
module irsir_bit_framer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic line_in,
    output logic zero_bit_start
);
    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);

    logic             framing_q;
    logic [CNT_W-1:0] tick_cnt_q;
    logic             at_boundary;

    // A new bit may begin when idle or on the last tick of the current bit.
    always_comb begin
        at_boundary    = !framing_q || (tick_cnt_q == LAST_TICK);
        zero_bit_start = baud_tick && !line_in && at_boundary;
    end

    // Track framing state and tick position within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            framing_q  <= 1'b0;
            tick_cnt_q <= '0;
        end else if (baud_tick) begin
            if (at_boundary) begin
                framing_q  <= !line_in;
                tick_cnt_q <= '0;
            end else begin
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irsir_cfg_hold.sv
// Module: irsir_cfg_hold
// Captures the mode bit and divisor when a pulse starts, so that a running
// pulse never sees a setting change. A divisor below DIV_MIN is raised to
// DIV_MIN on capture.
// Assumes: load is a one-cycle strobe issued at the start of a pulse.
module irsir_cfg_hold
    import irsir_pkg::*;
#(
    parameter int DIV_W     = 5,
    parameter int DIV_MIN   = 4,
    parameter int DIV_RESET = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             mode_in,
    input  logic [DIV_W-1:0] div_in,
    output irsir_mode_e      mode_q,
    output logic [DIV_W-1:0] div_q
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] RST_D = DIV_W'(DIV_RESET);

    logic [DIV_W-1:0] div_clamped;

    // Raise an undersized divisor to the permitted floor.
    always_comb begin
        div_clamped = (div_in < FLOOR) ? FLOOR : div_in;
    end

    // Hold the settings that belong to the pulse now running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FIXED;
            div_q  <= RST_D;
        end else if (load) begin
            mode_q <= irsir_mode_e'(mode_in);
            div_q  <= div_clamped;
        end
    end

endmodule

// File: rtl/irsir_ref_div.sv
// Module: irsir_ref_div
// Divides the system clock by the held divisor to make the fixed-mode
// reference strobe. Restarting aligns the reference grid to the start of
// the bit, so the first strobe arrives div cycles after the restart.
// Assumes: div is at least 2 (the capture stage guarantees a floor).
module irsir_ref_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             ref_tick
);
    logic [DIV_W-1:0] phase_q;

    // Strobe on the last phase of each reference period.
    always_comb begin
        ref_tick = run && (phase_q == (div - 1'b1));
    end

    // Advance the phase counter while the pulse needs the reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= ref_tick ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/irsir_pulse_gen.sv
// Module: irsir_pulse_gen
// Holds the infrared output high for PULSE_UNITS width units after a start.
// The unit is one baud tick in proportional mode and one reference period
// in fixed mode. A new start while high restarts the count.
// Assumes: mode is stable for the life of a pulse (held upstream).
module irsir_pulse_gen
    import irsir_pkg::*;
#(
    parameter int PULSE_UNITS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  irsir_mode_e mode,
    input  logic        baud_tick,
    input  logic        ref_tick,
    output logic        pulse_on,
    output logic        ref_run
);
    localparam int REM_W = $clog2(PULSE_UNITS + 1);
    localparam logic [REM_W-1:0] FULL = REM_W'(PULSE_UNITS);

    logic [REM_W-1:0] remain_q;
    logic             unit_tick;

    // Pick the width unit according to the held mode.
    always_comb begin
        unit_tick = (mode == MODE_PROP) ? baud_tick : ref_tick;
        ref_run   = pulse_on && (mode == MODE_FIXED);
    end

    // Count width units down and drop the output after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_on <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            pulse_on <= 1'b1;
            remain_q <= FULL;
        end else if (pulse_on && unit_tick) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == REM_W'(1)) begin
                pulse_on <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irsir_tx_mod.sv
// Module: irsir_tx_mod (top)
// Turns a UART transmit stream into infrared SIR pulses, one per logic-0
// bit. The width is either 3/16 of a bit (proportional) or a fixed number
// of divided-clock periods (fixed).
// Assumes: baud_x16_tick is a single-cycle strobe in the clk domain.
module irsir_tx_mod
    import irsir_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DIV_W       = 5,
    parameter int DIV_MIN     = 4,
    parameter int DIV_RESET   = 15,
    parameter int PULSE_UNITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uart_txd,
    input  logic             baud_x16_tick,
    input  logic             mode_prop,
    input  logic [DIV_W-1:0] ref_div,
    output logic             ir_txd_out
);
    logic             zero_start;
    irsir_mode_e      mode_q;
    logic [DIV_W-1:0] div_q;
    logic             ref_tick;
    logic             ref_run;

    irsir_bit_framer #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_framer (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_tick      (baud_x16_tick),
        .line_in        (uart_txd),
        .zero_bit_start (zero_start)
    );

    irsir_cfg_hold #(
        .DIV_W     (DIV_W),
        .DIV_MIN   (DIV_MIN),
        .DIV_RESET (DIV_RESET)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (zero_start),
        .mode_in (mode_prop),
        .div_in  (ref_div),
        .mode_q  (mode_q),
        .div_q   (div_q)
    );

    irsir_ref_div #(
        .DIV_W(DIV_W)
    ) u_refdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (zero_start),
        .run      (ref_run),
        .div      (div_q),
        .ref_tick (ref_tick)
    );

    irsir_pulse_gen #(
        .PULSE_UNITS(PULSE_UNITS)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (zero_start),
        .mode      (mode_q),
        .baud_tick (baud_x16_tick),
        .ref_tick  (ref_tick),
        .pulse_on  (ir_txd_out),
        .ref_run   (ref_run)
    );

endmodule

// File: rtl/irsir_tx_mod_chk.sv
// Module: irsir_tx_mod_chk
// Assertion checker for irsir_tx_mod, attached by bind below.
module irsir_tx_mod_chk
    import irsir_pkg::*;
#(
    parameter int DIV_W   = 5,
    parameter int DIV_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uart_txd,
    input logic             baud_x16_tick,
    input logic             ir_txd_out,
    input irsir_mode_e      mode_q,
    input logic [DIV_W-1:0] div_q,
    input logic             ref_tick
);
    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !ir_txd_out); // R1
    AST_NO_RISE_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uart_txd) |-> !$rose(ir_txd_out)); // R2
    AST_RISE_AFTER_ZERO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_txd_out) |-> $past(baud_x16_tick && !uart_txd)); // R3
    AST_PROP_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_txd_out) && mode_q == MODE_PROP) |-> $past(baud_x16_tick)); // R4
    AST_FIXED_END_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_txd_out) && mode_q == MODE_FIXED) |-> $past(ref_tick)); // R5
    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= DIV_W'(DIV_MIN)); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(baud_x16_tick && !uart_txd) |=> ($stable(mode_q) && $stable(div_q))); // R7
endmodule

bind irsir_tx_mod irsir_tx_mod_chk #(
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .uart_txd      (uart_txd),
    .baud_x16_tick (baud_x16_tick),
    .ir_txd_out    (ir_txd_out),
    .mode_q        (mode_q),
    .div_q         (div_q),
    .ref_tick      (ref_tick)
);

// File: tb/irsir_tx_mod_tb.sv
// Directed bench for irsir_tx_mod: one task per scenario.
module irsir_tx_mod_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 5;     // clocks per baud tick
    localparam int BIT_CYC    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_txd = 1'b1;
    logic       baud_x16_tick = 1'b0;
    logic       mode_prop = 1'b0;
    logic [4:0] ref_div = 5'd15;
    logic       ir_txd_out;

    int errors = 0;
    int checks = 0;
    int phase = 0;
    bit done = 0;

    // pulse log filled by the monitor
    int npulse = 0;
    int widths [0:15];
    int rise_bad = 0;
    int run_len = 0;
    logic prev_out = 1'b0;

    irsir_tx_mod u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .uart_txd      (uart_txd),
        .baud_x16_tick (baud_x16_tick),
        .mode_prop     (mode_prop),
        .ref_div       (ref_div),
        .ir_txd_out    (ir_txd_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: capture inputs at the edge, sample the output just after it.
    initial begin
        forever begin
            logic cap_tick, cap_txd;
            @(posedge clk);
            cap_tick = baud_x16_tick;
            cap_txd  = uart_txd;
            #1;
            if (ir_txd_out && !prev_out) begin
                if (!(cap_tick && !cap_txd)) rise_bad++;
                run_len = 1;
            end else if (ir_txd_out) begin
                run_len++;
            end else if (prev_out) begin
                if (npulse < 16) widths[npulse] = run_len;
                npulse++;
            end
            prev_out = ir_txd_out;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock of stimulus: the baud tick strobe comes every TICK_DIV clocks.
    task automatic cycle();
        @(negedge clk);
        baud_x16_tick = (phase == TICK_DIV - 1);
        phase = (phase + 1) % TICK_DIV;
    endtask

    task automatic clear_log();
        npulse = 0;
        rise_bad = 0;
    endtask

    // Send a frame; at frame cycle chg_at switch to proportional / divisor 4.
    task automatic send_frame(input logic [7:0] data, input int chg_at);
        int k = 0;
        for (int b = 0; b < 10; b++) begin
            if (b == 0) uart_txd = 1'b0;
            else if (b == 9) uart_txd = 1'b1;
            else uart_txd = data[b-1];
            for (int c = 0; c < BIT_CYC; c++) begin
                cycle();
                if (k == chg_at) begin
                    mode_prop = 1'b1;
                    ref_div   = 5'd4;
                end
                k++;
            end
        end
        for (int c = 0; c < 120; c++) cycle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int c = 0; c < 4; c++) cycle();
        check("R1 out low in reset", int'(ir_txd_out), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 6; c++) cycle();
        check("R1 out low after reset", int'(ir_txd_out), 0);
    endtask

    task automatic t_idle();
        clear_log();
        uart_txd = 1'b1;
        for (int c = 0; c < 300; c++) cycle();
        check("R2 idle line gives no pulse", npulse, 0);
    endtask

    task automatic t_prop();
        clear_log();
        mode_prop = 1'b1;
        ref_div   = 5'd15;
        send_frame(8'h35, -1);   // zeros: start, bits 1,3,6,7
        check("R2 one bits silent, pulse count", npulse, 5);
        check("R3 rise follows zero tick", rise_bad, 0);
        for (int i = 0; i < 5; i++) check("R4 proportional width", widths[i], 3 * TICK_DIV);
    endtask

    task automatic t_fixed(input logic [4:0] d, input int exp_w);
        clear_log();
        mode_prop = 1'b0;
        ref_div   = d;
        send_frame(8'hFF, -1);
        check("R3 single start pulse", npulse, 1);
        check("R3 rise follows zero tick", rise_bad, 0);
        if (d < 5'd4) check("R6 clamped width", widths[0], exp_w);
        else          check("R5 fixed width", widths[0], exp_w);
    endtask

    task automatic t_zeros();
        clear_log();
        mode_prop = 1'b0;
        ref_div   = 5'd22;
        send_frame(8'h00, -1);
        check("R8 pulses for all-zero byte", npulse, 9);
        for (int i = 0; i < 9; i++) check("R5 fixed width d22", widths[i], 66);
    endtask

    task automatic t_midchange();
        clear_log();
        mode_prop = 1'b0;
        ref_div   = 5'd15;
        send_frame(8'hFE, 10);   // zeros: start and bit 0
        check("R7 pulse count", npulse, 2);
        check("R7 width kept through change", widths[0], 45);
        check("R7 next pulse uses new mode", widths[1], 3 * TICK_DIV);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) widths[i] = 0;
        t_reset();
        t_idle();
        t_prop();
        t_fixed(5'd15, 45);
        t_fixed(5'd4, 12);
        t_fixed(5'd5, 15);
        t_fixed(5'd31, 93);
        t_fixed(5'd2, 12);
        t_fixed(5'd0, 12);
        t_zeros();
        t_midchange();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule